// File: doc/BRIEF.md
# Delta-Sigma Input Capture Unit

This block sits between the two pins of an external delta-sigma modulator (a clock pin and a data pin) and the decimation filters that follow it. It runs entirely in the fast system clock domain. It turns the pin activity into a single recovered bit and a one-cycle valid strobe for each modulator bit. Both pins are oversampled. Clock edges are found by comparing the current conditioned level of the clock pin with its previous level.

A 2-bit mode input selects how bits are recovered. The modulator clock may run at the bit rate, at half the bit rate (both edges used), or at twice the bit rate (every other rising edge used). In the fourth mode the modulator clock is not used and the data pin carries Manchester code. In that mode the decoder learns the bit period from the spacing of transitions. Each pin has its own enable for a two-stage synchronizer. When the synchronizer is off, the pin passes through a single register.

A watchdog counts system clocks without a modulator clock edge and raises a failure flag. The flag drives an interrupt output when the interrupt is enabled.

Top module: `dsm_capture`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bit_valid`, `clk_fail` and `clk_fail_irq` are 0.
- R2: With `mode_sel` = 0, one bit is captured on every rising edge of the modulator clock. The bit is the data pin level at that edge.
- R3: With `mode_sel` = 1, one bit is captured on every rising edge and on every falling edge of the modulator clock.
- R4: With `mode_sel` = 3, a bit is captured on every other rising edge. The first rising edge after reset or after a mode change captures, the next one does not, and so on. Falling edges capture nothing.
- R5: With `mode_sel` = 2, the data pin is decoded as Manchester code. A mid-bit transition from 0 to 1 gives a 1, and one from 1 to 0 gives a 0. Bits come out in transmission order, and the clock pin has no effect.
- R6: In Manchester mode, the learned period is the longest transition spacing seen since the line was last idle. A transition counts as mid-bit, and yields a bit, only when at least 3/4 of the learned period has passed since the previous mid-bit transition. The learned period is cleared after 255 cycles with no transition, or on a mode change.
- R7: In mode 0, a rising clock pin gives `bit_valid` after the third system clock edge with the synchronizers enabled, and after the second with them bypassed.
- R8: `clk_fail` rises after 64 consecutive system clocks with no modulator clock edge, and never earlier. It falls after the next detected edge.
- R9: `clk_fail_irq` is high only while `clk_fail` is high and `fail_irq_en` is 1.
- R10: In Manchester mode `clk_fail` stays 0, however long the clock pin is quiet.
- R11: `bit_valid` is high for exactly one cycle per captured bit, so the pulse count equals the number of bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_clk_pin | input | 1 | Raw modulator clock pin |
| mod_dat_pin | input | 1 | Raw modulator data pin |
| mode_sel | input | 2 | Capture mode: 0 same rate, 1 half rate, 2 Manchester, 3 double rate |
| clk_sync_en | input | 1 | 1 = clock pin through two-stage synchronizer, 0 = single register |
| dat_sync_en | input | 1 | 1 = data pin through two-stage synchronizer, 0 = single register |
| fail_irq_en | input | 1 | Enables the clock-failure interrupt |
| bit_out | output | 1 | Recovered modulator bit |
| bit_valid | output | 1 | One-cycle strobe marking a new `bit_out` |
| clk_fail | output | 1 | Modulator clock lost |
| clk_fail_irq | output | 1 | Clock-failure interrupt |

## Verification
The double-rate test sends data that changes between the two rising edges of each bit. A design that capture on both rising edges, or that start on the wrong phase, would deliver twice as many bits or the wrong ones. The Manchester payload contains runs of equal bits, so a decoder that took bit-boundary transitions as mid-bit would insert extra bits. A decoder that learned the period from the idle gap would drop bits. The clock watchdog is sampled both before and after the 64-cycle limit, which catches a counter that is off in either direction. The synchronizer test counts exact latency in both settings, which exposes a bypass that still adds a stage.

// File: rtl/dsm_cap_pkg.sv
package dsm_cap_pkg;

    typedef enum logic [1:0] {
        CAP_SAME   = 2'd0,
        CAP_HALF   = 2'd1,
        CAP_MANCH  = 2'd2,
        CAP_DOUBLE = 2'd3
    } cap_mode_e;

    // Conditioned pin: current level plus a change flag versus previous level
    typedef struct packed {
        logic lvl;
        logic chg;
    } pin_ev_t;

    // One recovered modulator bit
    typedef struct packed {
        logic valid;
        logic value;
    } beat_t;

    function automatic logic ev_rise(pin_ev_t e);
        return e.chg & e.lvl;
    endfunction

    function automatic logic ev_fall(pin_ev_t e);
        return e.chg & ~e.lvl;
    endfunction

    function automatic logic mode_uses_clock(cap_mode_e m);
        return m != CAP_MANCH;
    endfunction

endpackage

// File: rtl/dsm_pin_cond.sv
module dsm_pin_cond
    import dsm_cap_pkg::*;
#(
    parameter int STAGES = 2   // synchronizer depth, must be at least 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pin,
    input  logic    sync_en,
    output pin_ev_t ev
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              cur;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
        end
    end

    // Bypass keeps a single register so that edge detection stays registered
    assign cur = sync_en ? chain[LAST] : chain[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
        end else begin
            prev <= cur;
        end
    end

    always_comb begin
        ev.lvl = cur;
        ev.chg = cur ^ prev;
    end

endmodule

// File: rtl/dsm_clk_sampler.sv
module dsm_clk_sampler
    import dsm_cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  cap_mode_e mode,
    input  pin_ev_t   ck,
    input  logic      dat,
    output beat_t     beat
);
    logic phase;   // 0 = next rising edge captures in double-rate mode
    logic take;

    always_comb begin
        case (mode)
            CAP_SAME:   take = ev_rise(ck);
            CAP_HALF:   take = ck.chg;
            CAP_DOUBLE: take = ev_rise(ck) & ~phase;
            default:    take = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= 1'b0;
            beat  <= '0;
        end else begin
            if (mode == CAP_DOUBLE && ev_rise(ck)) begin
                phase <= ~phase;
            end
            beat.valid <= take;
            if (take) begin
                beat.value <= dat;
            end
        end
    end

endmodule

// File: rtl/dsm_manch_dec.sv
module dsm_manch_dec
    import dsm_cap_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    en,
    input  pin_ev_t d,
    output beat_t   beat
);
    localparam logic [CNT_W-1:0] SAT = '1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] gap;        // cycles since last transition
    logic [CNT_W-1:0] since_mid;  // cycles since last accepted mid-bit
    logic [CNT_W-1:0] per;        // learned bit period
    logic [CNT_W+1:0] lhs;
    logic [CNT_W+1:0] rhs;
    logic             mid_ok;

    // since_mid >= 3/4 * per, evaluated as 4*since_mid >= 3*per
    always_comb begin
        lhs    = {since_mid, 2'b00};
        rhs    = {2'b00, per} + {1'b0, per, 1'b0};
        mid_ok = lhs >= rhs;
    end

    always_ff @(posedge clk) begin
        if (rst || clr || !en) begin
            gap       <= SAT;
            since_mid <= SAT;
            per       <= '0;
            beat      <= '0;
        end else begin
            beat.valid <= 1'b0;
            if (d.chg) begin
                gap <= ONE;
                if (gap != SAT && gap > per) begin
                    per <= gap;
                end
                if (mid_ok) begin
                    beat.valid <= 1'b1;
                    beat.value <= d.lvl;
                    since_mid  <= ONE;
                end else if (since_mid != SAT) begin
                    since_mid <= since_mid + ONE;
                end
            end else begin
                if (gap != SAT) begin
                    gap <= gap + ONE;
                end else begin
                    per <= '0;
                end
                if (since_mid != SAT) begin
                    since_mid <= since_mid + ONE;
                end
            end
        end
    end

endmodule

// File: rtl/dsm_clk_watch.sv
module dsm_clk_watch #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic edge_seen,
    output logic fail
);
    localparam int            CW     = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

    logic [CW-1:0] quiet;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            quiet <= '0;
            fail  <= 1'b0;
        end else if (edge_seen) begin
            quiet <= '0;
            fail  <= 1'b0;
        end else begin
            if (quiet == LIM_M1) begin
                fail <= 1'b1;
            end else begin
                quiet <= quiet + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dsm_capture.sv
module dsm_capture
    import dsm_cap_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAN_CNT_W   = 8,
    parameter int FAIL_LIMIT  = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mod_clk_pin,
    input  logic       mod_dat_pin,
    input  logic [1:0] mode_sel,
    input  logic       clk_sync_en,
    input  logic       dat_sync_en,
    input  logic       fail_irq_en,
    output logic       bit_out,
    output logic       bit_valid,
    output logic       clk_fail,
    output logic       clk_fail_irq
);
    cap_mode_e mode;
    cap_mode_e mode_q;
    logic      mode_clr;
    pin_ev_t   clk_ev;
    pin_ev_t   dat_ev;
    beat_t     smp_beat;
    beat_t     man_beat;
    beat_t     sel_beat;

    assign mode = cap_mode_e'(mode_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= CAP_SAME;
        end else begin
            mode_q <= mode;
        end
    end

    assign mode_clr = (mode != mode_q);

    dsm_pin_cond #(.STAGES(SYNC_STAGES)) u_clk_cond (
        .clk     (clk),
        .rst     (rst),
        .pin     (mod_clk_pin),
        .sync_en (clk_sync_en),
        .ev      (clk_ev)
    );

    dsm_pin_cond #(.STAGES(SYNC_STAGES)) u_dat_cond (
        .clk     (clk),
        .rst     (rst),
        .pin     (mod_dat_pin),
        .sync_en (dat_sync_en),
        .ev      (dat_ev)
    );

    dsm_clk_sampler u_sampler (
        .clk  (clk),
        .rst  (rst),
        .clr  (mode_clr),
        .mode (mode),
        .ck   (clk_ev),
        .dat  (dat_ev.lvl),
        .beat (smp_beat)
    );

    dsm_manch_dec #(.CNT_W(MAN_CNT_W)) u_manch (
        .clk  (clk),
        .rst  (rst),
        .clr  (mode_clr),
        .en   (mode == CAP_MANCH),
        .d    (dat_ev),
        .beat (man_beat)
    );

    dsm_clk_watch #(.LIMIT(FAIL_LIMIT)) u_watch (
        .clk       (clk),
        .rst       (rst),
        .en        (mode_uses_clock(mode)),
        .edge_seen (clk_ev.chg),
        .fail      (clk_fail)
    );

    assign sel_beat     = (mode == CAP_MANCH) ? man_beat : smp_beat;
    assign bit_out      = sel_beat.value;
    assign bit_valid    = sel_beat.valid;
    assign clk_fail_irq = clk_fail & fail_irq_en;

endmodule

// File: rtl/dsm_capture_chk.sv
module dsm_capture_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic       bit_out,
    input logic       bit_valid,
    input logic       clk_fail,
    input logic       clk_lvl,
    input logic       clk_chg,
    input logic       dat_lvl,
    input logic       dat_chg
);
    logic clk_rise;
    assign clk_rise = clk_lvl & clk_chg;

    AST_SAME_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd0 && $past(mode_sel) == 2'd0 && bit_valid)
            |-> ($past(clk_rise) && bit_out == $past(dat_lvl))); // R2

    AST_HALF_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd1 && $past(mode_sel) == 2'd1 && bit_valid)
            |-> ($past(clk_chg) && bit_out == $past(dat_lvl))); // R3

    AST_DOUBLE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd3 && $past(mode_sel) == 2'd3 && bit_valid)
            |-> ($past(clk_rise) && bit_out == $past(dat_lvl))); // R4

    AST_MANCH_ON_TRANSITION: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd2 && $past(mode_sel) == 2'd2 && bit_valid)
            |-> ($past(dat_chg) && bit_out == $past(dat_lvl))); // R5

    AST_FAIL_AFTER_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_fail) |-> !$past(clk_chg)); // R8

    AST_FAIL_CLEARS_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $past(clk_chg) |-> !clk_fail); // R8

    AST_MANCH_NO_FAIL: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_sel) == 2'd2) |-> !clk_fail); // R10

endmodule

bind dsm_capture dsm_capture_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .bit_out   (bit_out),
    .bit_valid (bit_valid),
    .clk_fail  (clk_fail),
    .clk_lvl   (clk_ev.lvl),
    .clk_chg   (clk_ev.chg),
    .dat_lvl   (dat_ev.lvl),
    .dat_chg   (dat_ev.chg)
);

// File: tb/tb_dsm_capture.sv
module tb_dsm_capture;

    logic       clk = 1'b0;
    logic       rst;
    logic       mod_clk_pin;
    logic       mod_dat_pin;
    logic [1:0] mode_sel;
    logic       clk_sync_en;
    logic       dat_sync_en;
    logic       fail_irq_en;
    logic       bit_out;
    logic       bit_valid;
    logic       clk_fail;
    logic       clk_fail_irq;

    int n_chk = 0;
    int n_err = 0;
    int rx_cnt = 0;
    logic rx_bits [0:63];

    always #5 clk = ~clk;

    dsm_capture dut (
        .clk          (clk),
        .rst          (rst),
        .mod_clk_pin  (mod_clk_pin),
        .mod_dat_pin  (mod_dat_pin),
        .mode_sel     (mode_sel),
        .clk_sync_en  (clk_sync_en),
        .dat_sync_en  (dat_sync_en),
        .fail_irq_en  (fail_irq_en),
        .bit_out      (bit_out),
        .bit_valid    (bit_valid),
        .clk_fail     (clk_fail),
        .clk_fail_irq (clk_fail_irq)
    );

    // Collect recovered bits, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst && bit_valid) begin
            if (rx_cnt < 64) rx_bits[rx_cnt] = bit_out;
            rx_cnt = rx_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic prep(input logic [1:0] m, input logic sync);
        @(negedge clk);
        mod_clk_pin = 1'b0;
        mod_dat_pin = 1'b0;
        clk_sync_en = sync;
        dat_sync_en = sync;
        mode_sel    = m;
        wait_n(12);
        rx_cnt = 0;
    endtask

    task automatic chk_bits(input string req, input logic [15:0] pat, input int first);
        for (int i = 0; i < 16; i++) begin
            chk(req, int'(rx_bits[first + i]), int'(pat[15 - i]));
        end
    endtask

    // R1
    task automatic t_reset();
        chk("R1 bit_valid", int'(bit_valid), 0);
        chk("R1 clk_fail", int'(clk_fail), 0);
        chk("R1 clk_fail_irq", int'(clk_fail_irq), 0);
    endtask

    // R2, R11: rising-edge capture at the bit rate
    task automatic t_same(input logic [15:0] pat, input logic sync);
        prep(2'd0, sync);
        for (int i = 15; i >= 0; i--) begin
            mod_clk_pin = 1'b0;
            mod_dat_pin = pat[i];
            wait_n(4);
            mod_clk_pin = 1'b1;
            wait_n(4);
        end
        mod_clk_pin = 1'b0;
        wait_n(6);
        chk("R11 mode0 bit count", rx_cnt, 16);
        chk_bits("R2 mode0 bit", pat, 0);
    endtask

    // R3: both clock edges
    task automatic t_half(input logic [15:0] pat);
        prep(2'd1, 1'b1);
        for (int i = 15; i >= 0; i--) begin
            mod_dat_pin = pat[i];
            wait_n(4);
            mod_clk_pin = ~mod_clk_pin;
            wait_n(4);
        end
        wait_n(6);
        chk("R3 mode1 bit count", rx_cnt, 16);
        chk_bits("R3 mode1 bit", pat, 0);
    endtask

    // R4: every other rising edge; data flips between the two rises
    task automatic t_double(input logic [15:0] pat);
        prep(2'd3, 1'b1);
        for (int i = 15; i >= 0; i--) begin
            mod_dat_pin = pat[i];
            wait_n(2);
            mod_clk_pin = 1'b1;
            wait_n(2);
            mod_clk_pin = 1'b0;
            mod_dat_pin = ~pat[i];
            wait_n(2);
            mod_clk_pin = 1'b1;
            wait_n(2);
            mod_clk_pin = 1'b0;
        end
        wait_n(6);
        chk("R4 mode3 bit count", rx_cnt, 16);
        chk_bits("R4 mode3 bit", pat, 0);
    endtask

    task automatic man_bit(input logic b);
        mod_dat_pin = ~b;
        mod_clk_pin = ~mod_clk_pin;
        wait_n(8);
        mod_dat_pin = b;
        mod_clk_pin = ~mod_clk_pin;
        wait_n(8);
    endtask

    // R5, R6, R10: Manchester with runs of equal bits, clock pin toggling
    task automatic t_manch(input logic [15:0] pat);
        prep(2'd2, 1'b1);
        for (int i = 0; i < 6; i++) man_bit(i[0]);
        for (int i = 15; i >= 0; i--) man_bit(pat[i]);
        wait_n(10);
        chk("R5 mode2 count low", int'(rx_cnt >= 16), 1);
        chk("R6 mode2 count high", int'(rx_cnt <= 23), 1);
        if (rx_cnt >= 16 && rx_cnt <= 64) chk_bits("R5 R6 mode2 bit", pat, rx_cnt - 16);
        wait_n(120);
        chk("R10 mode2 no clk_fail", int'(clk_fail), 0);
    endtask

    // R7: latency from clock pin rise to bit_valid
    task automatic t_latency(input logic sync, input int exp);
        int lat = 0;
        prep(2'd0, sync);
        mod_dat_pin = 1'b1;
        wait_n(4);
        mod_clk_pin = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (bit_valid && lat == 0) lat = k;
        end
        chk("R7 latency", lat, exp);
    endtask

    // R8, R9: clock loss watchdog and interrupt gating
    task automatic t_fail();
        prep(2'd0, 1'b1);
        fail_irq_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            mod_clk_pin = ~mod_clk_pin;
            wait_n(4);
        end
        chk("R8 running clock no fail", int'(clk_fail), 0);
        mod_clk_pin = 1'b0;
        wait_n(50);
        chk("R8 no fail before limit", int'(clk_fail), 0);
        chk("R9 irq low without fail", int'(clk_fail_irq), 0);
        wait_n(30);
        chk("R8 fail after limit", int'(clk_fail), 1);
        chk("R9 irq with enable", int'(clk_fail_irq), 1);
        fail_irq_en = 1'b0;
        wait_n(1);
        chk("R9 irq masked", int'(clk_fail_irq), 0);
        chk("R9 flag kept when masked", int'(clk_fail), 1);
        fail_irq_en = 1'b1;
        mod_clk_pin = 1'b1;
        wait_n(5);
        chk("R8 fail clears on edge", int'(clk_fail), 0);
    endtask

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst         = 1'b1;
        mod_clk_pin = 1'b0;
        mod_dat_pin = 1'b0;
        mode_sel    = 2'd0;
        clk_sync_en = 1'b1;
        dat_sync_en = 1'b1;
        fail_irq_en = 1'b1;
        wait_n(5);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_same(16'b1011_0011_1000_1101, 1'b1);
        t_same(16'b0100_1111_0110_0001, 1'b0);
        t_half(16'b1100_1010_0111_0001);
        t_double(16'b1001_1100_0101_1110);
        t_manch(16'b1110_0010_1100_1011);
        t_latency(1'b1, 3);
        t_latency(1'b0, 2);
        t_fail();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule